// File: doc/BRIEF.md
# Ethernet Buffer Descriptor Ring Sequencer

This block owns the descriptor table that an Ethernet MAC shares with software. Each table entry is two 32-bit words: a status/length word and a buffer address word. The table is split into a transmit ring and a receive ring at a programmable transmit count. Each ring is closed by a wrap flag in a descriptor, not by a fixed depth. Software fills descriptors and reads them back through a simple word-wide register port. The same port carries a control word that enables each direction, and the transmit count.

On the transmit side the sequencer polls the descriptor under its pointer. When software has marked that descriptor as hardware-owned, the sequencer presents its buffer address, length and per-frame options to the MAC. It waits for the MAC's completion, writes the result fields back and hands the descriptor back to software. On the receive side a frame start from the MAC claims the current descriptor if software has left it empty. The frame end records the length and error flags. When the current descriptor is not empty, the frame is refused and a busy pulse is raised. Done, error and busy pulses are one cycle wide.

Top module: `bd_ring_seq`

## Requirements
- R1: Word offsets: 0x00 is the control word (bit 0 transmit enable, bit 1 receive enable, reset 0), 0x04 is the transmit count (reset 64, half the table), and descriptor i sits at 0x400 + 8*i with its status word at +0 and its address word at +4. Other offsets read as 0.
- R2: A transmit count written above the table size (128) is stored as 128; any other value is stored as written.
- R3: With transmit enabled and status bit 15 set on the descriptor under the transmit pointer, `txReq` rises. While it is high, `txBufAddr` shows the address word, `txLen` bits 31:16, `txPad` bit 12 and `txCrc` bit 11. `txReq` stays high until `txDone`.
- R4: On transmit completion the status word keeps bits 31:16 and 14:9, clears bit 15, and takes `txResult` into bits 8:0.
- R5: A transmit completion pulses `irqPulse[0]` when bit 14 of the descriptor is set and `txResult` bits 8, 3, 2 and 0 are all clear. It pulses `irqPulse[1]` instead when bit 14 is set and any of those bits is set. It pulses nothing when bit 14 is clear.
- R6: After a descriptor whose bit 13 is set, the pointer returns to the ring's first descriptor: index 0 for transmit, index N (the transmit count) for receive. Otherwise the pointer moves to the next index.
- R7: A `rxStart` pulse with receive enabled, while the descriptor under the receive pointer has bit 15 set, raises `rxOpen` with `rxBufAddr` equal to that descriptor's address word. `rxOpen` stays high until `rxEnd`.
- R8: On `rxEnd` the status word takes `rxLen` into bits 31:16 and `rxFlags` into bits 8:0, clears bit 15 and keeps bits 14:9. When bit 14 is set, `irqPulse[3]` pulses if any of flag bits 6, 5, 3, 2, 1, 0 is set, and `irqPulse[2]` pulses otherwise.
- R9: A `rxStart` with receive enabled that cannot claim a descriptor pulses `irqPulse[4]`, leaves `rxOpen` low and leaves the receive pointer in place. With receive disabled, `rxStart` is ignored with no pulse.
- R10: A 0-to-1 change of a direction's enable bit moves that ring's pointer back to its first descriptor.
- R11: Ownership bits are re-read every cycle. A descriptor that is not yet owned holds the sequencer at that index until software sets the bit, and nothing is fetched while the direction is disabled.
- R12: If software writes a status word in the same cycle that the sequencer would write that word back, the software value is stored. The write-back and its interrupt pulse then follow one cycle later, applied on top of the software value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| swWe | input | 1 | Software write strobe |
| swAddr | input | 12 | Software byte offset |
| swWdata | input | 32 | Software write data |
| swRdata | output | 32 | Software read data for `swAddr` |
| txReq | output | 1 | Transmit descriptor presented to the MAC |
| txBufAddr | output | 32 | Transmit buffer address |
| txLen | output | 16 | Transmit frame length |
| txPad | output | 1 | Pad short frame |
| txCrc | output | 1 | Append CRC |
| txDone | input | 1 | MAC finished the presented frame |
| txResult | input | 9 | Transmit result fields for status bits 8:0 |
| rxStart | input | 1 | MAC begins a received frame |
| rxOpen | output | 1 | A receive descriptor is claimed |
| rxBufAddr | output | 32 | Receive buffer address |
| rxEnd | input | 1 | Received frame complete |
| rxLen | input | 16 | Received length including CRC |
| rxFlags | input | 9 | Receive flag fields for status bits 8:0 |
| irqPulse | output | 5 | Pulses: tx done, tx error, rx done, rx error, busy |

## Verification
A hardware write-back and a software write can hit the same status word in the same cycle. The bench provokes this by driving a software write to the transmit status word on the exact negative edge after `txDone` is released, so that the write lands on the write-back edge. It judges the result from the ports: in the next cycle the word must read as the software value with no interrupt pulse. One cycle later the word must read as the software value with bit 15 cleared and the result fields merged in, and the error pulse must appear.

// File: rtl/bd_ring_seq_pkg.sv
package bd_ring_seq_pkg;

  localparam int TABLE_BASE = 'h400;

  localparam int ST_OWN  = 15;
  localparam int ST_IRQ  = 14;
  localparam int ST_WRAP = 13;
  localparam int ST_PAD  = 12;
  localparam int ST_CRC  = 11;

  // result bits that count as a failed frame
  localparam logic [8:0] TX_ERR_MASK = 9'h10D;
  localparam logic [8:0] RX_ERR_MASK = 9'h06F;

  localparam int IRQ_TX_DONE = 0;
  localparam int IRQ_TX_ERR  = 1;
  localparam int IRQ_RX_DONE = 2;
  localparam int IRQ_RX_ERR  = 3;
  localparam int IRQ_BUSY    = 4;
  localparam int IRQ_W       = 5;

  typedef struct packed {
    logic txCapture;
    logic txWb;
    logic rxCapture;
    logic rxWb;
  } seqStrobes_t;

endpackage

// File: rtl/bd_ring_datapath.sv
module bd_ring_datapath
  import bd_ring_seq_pkg::*;
#(
  parameter int NUM_DESC = 128,
  parameter int ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swWe,
  input  logic [ADDR_W-1:0] swAddr,
  input  logic [31:0]       swWdata,
  output logic [31:0]       swRdata,
  input  seqStrobes_t       strobes,
  input  logic [8:0]        txResult,
  input  logic [15:0]       rxLen,
  input  logic [8:0]        rxFlags,
  output logic              txOwned,
  output logic              rxAvail,
  output logic              rxEn,
  output logic              txHit,
  output logic              rxHit,
  output logic              txIrqEn,
  output logic              txErr,
  output logic              rxIrqEn,
  output logic              rxErr,
  output logic [31:0]       txBufAddr,
  output logic [15:0]       txLen,
  output logic              txPad,
  output logic              txCrc,
  output logic [31:0]       rxBufAddr
);

  localparam int IDX_W   = $clog2(NUM_DESC);
  localparam int PTR_W   = IDX_W + 1;
  localparam int TBL_END = TABLE_BASE + 8 * NUM_DESC;
  localparam logic [ADDR_W-1:0] CTRL_OFS  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] COUNT_OFS = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] TBL_LO    = ADDR_W'(TABLE_BASE);
  localparam logic [PTR_W-1:0]  LAST_IDX  = PTR_W'(NUM_DESC - 1);
  localparam logic [PTR_W-1:0]  HALF_IDX  = PTR_W'(NUM_DESC / 2);

  logic [31:0] statMem [NUM_DESC];
  logic [31:0] addrMem [NUM_DESC];

  logic [1:0]       ctrlQ;
  logic [PTR_W-1:0] txCountQ;
  logic [PTR_W-1:0] txPtr;
  logic [PTR_W-1:0] rxPtr;
  logic [8:0]       txResQ;
  logic [15:0]      rxLenQ;
  logic [8:0]       rxFlagsQ;

  logic              swInTable;
  logic [ADDR_W-1:0] swOff;
  logic [IDX_W-1:0]  swIdx;
  logic              swStatWr;
  logic [IDX_W-1:0]  txIdx;
  logic [IDX_W-1:0]  rxIdx;
  logic              txValid;
  logic              rxValid;
  logic              txDoWb;
  logic              rxDoWb;
  logic [31:0]       txNewWord;
  logic [31:0]       rxNewWord;
  logic [PTR_W-1:0]  txNext;
  logic [PTR_W-1:0]  rxNext;
  logic              ctrlWr;
  logic              txRise;
  logic              rxRise;

  // ---- software address decode
  assign swInTable = (int'(swAddr) >= TABLE_BASE) && (int'(swAddr) < TBL_END);
  assign swOff     = swAddr - TBL_LO;
  assign swIdx     = IDX_W'(swOff >> 3);
  assign swStatWr  = swWe && swInTable && !swAddr[2];

  // ---- ring positions
  assign txIdx   = txPtr[IDX_W-1:0];
  assign rxIdx   = rxPtr[IDX_W-1:0];
  assign txValid = txPtr < txCountQ;
  assign rxValid = rxPtr <= LAST_IDX;

  assign txOwned = ctrlQ[0] && txValid && statMem[txIdx][ST_OWN];
  assign rxAvail = ctrlQ[1] && rxValid && statMem[rxIdx][ST_OWN];
  assign rxEn    = ctrlQ[1];

  assign txHit = swStatWr && (swIdx == txIdx);
  assign rxHit = swStatWr && (swIdx == rxIdx);

  assign txDoWb = strobes.txWb && !txHit && txValid;
  assign rxDoWb = strobes.rxWb && !rxHit && rxValid;

  assign txIrqEn = statMem[txIdx][ST_IRQ];
  assign rxIrqEn = statMem[rxIdx][ST_IRQ];
  assign txErr   = |(txResQ & TX_ERR_MASK);
  assign rxErr   = |(rxFlagsQ & RX_ERR_MASK);

  assign txNewWord = {statMem[txIdx][31:16], 1'b0, statMem[txIdx][14:9], txResQ};
  assign rxNewWord = {rxLenQ, 1'b0, statMem[rxIdx][14:9], rxFlagsQ};

  assign txNext = (statMem[txIdx][ST_WRAP] || txPtr >= LAST_IDX) ? '0 : txPtr + 1'b1;
  assign rxNext = (statMem[rxIdx][ST_WRAP] || rxPtr >= LAST_IDX) ? txCountQ : rxPtr + 1'b1;

  assign ctrlWr = swWe && (swAddr == CTRL_OFS);
  assign txRise = ctrlWr && swWdata[0] && !ctrlQ[0];
  assign rxRise = ctrlWr && swWdata[1] && !ctrlQ[1];

  // ---- MAC-facing views of the current descriptors
  assign txBufAddr = addrMem[txIdx];
  assign txLen     = statMem[txIdx][31:16];
  assign txPad     = statMem[txIdx][ST_PAD];
  assign txCrc     = statMem[txIdx][ST_CRC];
  assign rxBufAddr = addrMem[rxIdx];

  // ---- descriptor table; the software write is ordered last and wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_DESC; i++) begin
        statMem[i] <= '0;
        addrMem[i] <= '0;
      end
    end else begin
      if (txDoWb) statMem[txIdx] <= txNewWord;
      if (rxDoWb) statMem[rxIdx] <= rxNewWord;
      if (swWe && swInTable) begin
        if (swAddr[2]) addrMem[swIdx] <= swWdata;
        else           statMem[swIdx] <= swWdata;
      end
    end
  end

  // ---- control registers, pointers and captured results
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      txCountQ <= HALF_IDX;
      txPtr    <= '0;
      rxPtr    <= HALF_IDX;
      txResQ   <= '0;
      rxLenQ   <= '0;
      rxFlagsQ <= '0;
    end else begin
      if (ctrlWr) ctrlQ <= swWdata[1:0];
      if (swWe && swAddr == COUNT_OFS)
        txCountQ <= (swWdata > 32'(NUM_DESC)) ? PTR_W'(NUM_DESC) : PTR_W'(swWdata);

      if (txRise)      txPtr <= '0;
      else if (txDoWb) txPtr <= txNext;

      if (rxRise)      rxPtr <= txCountQ;
      else if (rxDoWb) rxPtr <= rxNext;

      if (strobes.txCapture) txResQ <= txResult;
      if (strobes.rxCapture) begin
        rxLenQ   <= rxLen;
        rxFlagsQ <= rxFlags;
      end
    end
  end

  // ---- software read mux
  always_comb begin
    swRdata = '0;
    if (swAddr == CTRL_OFS)       swRdata = {30'b0, ctrlQ};
    else if (swAddr == COUNT_OFS) swRdata = 32'(txCountQ);
    else if (swInTable)           swRdata = swAddr[2] ? addrMem[swIdx] : statMem[swIdx];
  end

endmodule

// File: rtl/bd_ring_control.sv
module bd_ring_control
  import bd_ring_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             txOwned,
  input  logic             rxAvail,
  input  logic             rxEn,
  input  logic             txHit,
  input  logic             rxHit,
  input  logic             txIrqEn,
  input  logic             txErr,
  input  logic             rxIrqEn,
  input  logic             rxErr,
  input  logic             txDone,
  input  logic             rxStart,
  input  logic             rxEnd,
  output seqStrobes_t      strobes,
  output logic             txReq,
  output logic             rxOpen,
  output logic [IRQ_W-1:0] irqPulse
);

  typedef enum logic [1:0] {T_IDLE, T_REQ, T_WB} txState_e;
  typedef enum logic [1:0] {R_IDLE, R_OPEN, R_WB} rxState_e;

  txState_e txState;
  rxState_e rxState;
  logic [IRQ_W-1:0] irqNext;
  logic txWbOk;
  logic rxWbOk;

  assign strobes.txCapture = (txState == T_REQ) && txDone;
  assign strobes.txWb      = (txState == T_WB);
  assign strobes.rxCapture = (rxState == R_OPEN) && rxEnd;
  assign strobes.rxWb      = (rxState == R_WB);

  assign txWbOk = strobes.txWb && !txHit;
  assign rxWbOk = strobes.rxWb && !rxHit;

  assign txReq  = (txState == T_REQ);
  assign rxOpen = (rxState == R_OPEN);

  always_comb begin
    irqNext = '0;
    irqNext[IRQ_TX_DONE] = txWbOk && txIrqEn && !txErr;
    irqNext[IRQ_TX_ERR]  = txWbOk && txIrqEn && txErr;
    irqNext[IRQ_RX_DONE] = rxWbOk && rxIrqEn && !rxErr;
    irqNext[IRQ_RX_ERR]  = rxWbOk && rxIrqEn && rxErr;
    irqNext[IRQ_BUSY]    = rxStart && rxEn && !((rxState == R_IDLE) && rxAvail);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState  <= T_IDLE;
      rxState  <= R_IDLE;
      irqPulse <= '0;
    end else begin
      irqPulse <= irqNext;
      unique case (txState)
        T_IDLE:  if (txOwned) txState <= T_REQ;
        T_REQ:   if (txDone)  txState <= T_WB;
        T_WB:    if (!txHit)  txState <= T_IDLE;
        default: txState <= T_IDLE;
      endcase
      unique case (rxState)
        R_IDLE:  if (rxStart && rxEn && rxAvail) rxState <= R_OPEN;
        R_OPEN:  if (rxEnd)  rxState <= R_WB;
        R_WB:    if (!rxHit) rxState <= R_IDLE;
        default: rxState <= R_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bd_ring_seq.sv
module bd_ring_seq
  import bd_ring_seq_pkg::*;
#(
  parameter int NUM_DESC = 128,
  parameter int ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swWe,
  input  logic [ADDR_W-1:0] swAddr,
  input  logic [31:0]       swWdata,
  output logic [31:0]       swRdata,
  output logic              txReq,
  output logic [31:0]       txBufAddr,
  output logic [15:0]       txLen,
  output logic              txPad,
  output logic              txCrc,
  input  logic              txDone,
  input  logic [8:0]        txResult,
  input  logic              rxStart,
  output logic              rxOpen,
  output logic [31:0]       rxBufAddr,
  input  logic              rxEnd,
  input  logic [15:0]       rxLen,
  input  logic [8:0]        rxFlags,
  output logic [IRQ_W-1:0]  irqPulse
);

  seqStrobes_t strobes;
  logic txOwned, rxAvail, rxEn, txHit, rxHit;
  logic txIrqEn, txErr, rxIrqEn, rxErr;

  bd_ring_datapath #(.NUM_DESC(NUM_DESC), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .swWe(swWe), .swAddr(swAddr), .swWdata(swWdata), .swRdata(swRdata),
    .strobes(strobes), .txResult(txResult), .rxLen(rxLen), .rxFlags(rxFlags),
    .txOwned(txOwned), .rxAvail(rxAvail), .rxEn(rxEn),
    .txHit(txHit), .rxHit(rxHit),
    .txIrqEn(txIrqEn), .txErr(txErr), .rxIrqEn(rxIrqEn), .rxErr(rxErr),
    .txBufAddr(txBufAddr), .txLen(txLen), .txPad(txPad), .txCrc(txCrc),
    .rxBufAddr(rxBufAddr)
  );

  bd_ring_control u_ctl (
    .clk(clk), .rstN(rstN),
    .txOwned(txOwned), .rxAvail(rxAvail), .rxEn(rxEn),
    .txHit(txHit), .rxHit(rxHit),
    .txIrqEn(txIrqEn), .txErr(txErr), .rxIrqEn(rxIrqEn), .rxErr(rxErr),
    .txDone(txDone), .rxStart(rxStart), .rxEnd(rxEnd),
    .strobes(strobes), .txReq(txReq), .rxOpen(rxOpen), .irqPulse(irqPulse)
  );

endmodule

// File: rtl/bd_ring_checker.sv
module bd_ring_checker (
  input logic       clk,
  input logic       rstN,
  input logic       txReq,
  input logic       txDone,
  input logic       rxStart,
  input logic       rxOpen,
  input logic       rxEnd,
  input logic [4:0] irqPulse
);

  // R3: a presented descriptor is not withdrawn before the MAC finishes
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    txReq && !txDone |=> txReq);

  // R5: a transmit completion is either done or error, never both
  p_tx_irq_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqPulse[1:0]));

  // R5: completion pulses appear only once the request has been released
  p_tx_irq_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse[1:0] != 2'b00) |-> !txReq);

  // R7: a claimed receive buffer stays open until the frame ends
  p_rx_open_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxOpen && !rxEnd |=> rxOpen);

  // R8: a receive completion is either done or error, never both
  p_rx_irq_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqPulse[3:2]));

  // R9: a busy pulse always follows a frame start
  p_busy_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse[4] |-> $past(rxStart));

endmodule

bind bd_ring_seq bd_ring_checker u_chk (
  .clk(clk), .rstN(rstN), .txReq(txReq), .txDone(txDone),
  .rxStart(rxStart), .rxOpen(rxOpen), .rxEnd(rxEnd), .irqPulse(irqPulse)
);

// File: tb/bd_ring_seq_test.sv
`timescale 1ns/1ps
module bd_ring_seq_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        swWe;
  logic [11:0] swAddr;
  logic [31:0] swWdata;
  logic [31:0] swRdata;
  logic        txReq;
  logic [31:0] txBufAddr;
  logic [15:0] txLen;
  logic        txPad;
  logic        txCrc;
  logic        txDone;
  logic [8:0]  txResult;
  logic        rxStart;
  logic        rxOpen;
  logic [31:0] rxBufAddr;
  logic        rxEnd;
  logic [15:0] rxLen;
  logic [8:0]  rxFlags;
  logic [4:0]  irqPulse;

  int total = 0;
  int fails = 0;
  logic [31:0] txStat [3];
  logic [31:0] rxStat [6];

  always #2 clk = ~clk;

  bd_ring_seq uut (
    .clk(clk), .rstN(rstN), .swWe(swWe), .swAddr(swAddr), .swWdata(swWdata),
    .swRdata(swRdata), .txReq(txReq), .txBufAddr(txBufAddr), .txLen(txLen),
    .txPad(txPad), .txCrc(txCrc), .txDone(txDone), .txResult(txResult),
    .rxStart(rxStart), .rxOpen(rxOpen), .rxBufAddr(rxBufAddr), .rxEnd(rxEnd),
    .rxLen(rxLen), .rxFlags(rxFlags), .irqPulse(irqPulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic swWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    swWe = 1'b1; swAddr = a; swWdata = d;
    @(negedge clk);
    swWe = 1'b0;
  endtask

  task automatic swRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    swAddr = a;
    #1 d = swRdata;
  endtask

  function automatic logic [31:0] txAddrOf(input int i);
    return 32'h1000 + 32'(i) * 32'h600;
  endfunction

  function automatic logic [31:0] rxAddrOf(input int i);
    return 32'h8000 + 32'(i) * 32'h600;
  endfunction

  task automatic waitTxReq();
    int n = 0;
    while (!txReq && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk("R3 request raised", 32'(txReq), 32'd1);
  endtask

  // serve one transmit frame and check presentation, irq and write-back
  task automatic txFrame(input string tag, input int idx, input logic [8:0] res,
                         input logic [31:0] stat);
    logic [31:0] rd;
    logic [4:0] expIrq;
    logic err;
    waitTxReq();
    chk({tag, " R3/R6 txBufAddr"}, txBufAddr, txAddrOf(idx));
    chk("R3 txLen", 32'(txLen), 32'(stat[31:16]));
    chk("R3 txPad", 32'(txPad), 32'(stat[12]));
    chk("R3 txCrc", 32'(txCrc), 32'(stat[11]));
    txDone = 1'b1; txResult = res;
    @(negedge clk);
    txDone = 1'b0;
    @(negedge clk);
    err = res[8] | res[3] | res[2] | res[0];
    expIrq = stat[14] ? (err ? 5'b00010 : 5'b00001) : 5'b00000;
    chk("R5 tx irq", 32'(irqPulse), 32'(expIrq));
    swRead(12'h400 + 12'(idx * 8), rd);
    chk("R4 tx write-back", rd, (stat & ~32'h0000_81FF) | 32'(res));
  endtask

  // receive one frame into descriptor idx
  task automatic rxFrame(input string tag, input int idx, input logic [15:0] len,
                         input logic [8:0] flags, input logic [31:0] stat);
    logic [31:0] rd;
    logic [4:0] expIrq;
    logic err;
    @(negedge clk);
    rxStart = 1'b1;
    @(negedge clk);
    rxStart = 1'b0;
    chk("R7 rxOpen", 32'(rxOpen), 32'd1);
    chk({tag, " R7/R6 rxBufAddr"}, rxBufAddr, rxAddrOf(idx));
    rxEnd = 1'b1; rxLen = len; rxFlags = flags;
    @(negedge clk);
    rxEnd = 1'b0;
    @(negedge clk);
    err = |(flags & 9'h06F);
    expIrq = stat[14] ? (err ? 5'b01000 : 5'b00100) : 5'b00000;
    chk("R8 rx irq", 32'(irqPulse), 32'(expIrq));
    swRead(12'h400 + 12'(idx * 8), rd);
    chk("R8 rx write-back", rd, {len, 1'b0, stat[14:9], flags});
  endtask

  task automatic rxRefused(input string tag, input logic [4:0] expIrq);
    @(negedge clk);
    rxStart = 1'b1;
    @(negedge clk);
    rxStart = 1'b0;
    chk({tag, " R9 irq"}, 32'(irqPulse), 32'(expIrq));
    chk({tag, " R9 rxOpen"}, 32'(rxOpen), 32'd0);
  endtask

  initial begin
    #(4 * 150000);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rstN = 1'b0; swWe = 1'b0; swAddr = '0; swWdata = '0;
    txDone = 1'b0; txResult = '0; rxStart = 1'b0; rxEnd = 1'b0;
    rxLen = '0; rxFlags = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 txReq at reset", 32'(txReq), 32'd0);
    chk("R1 rxOpen at reset", 32'(rxOpen), 32'd0);
    chk("R1 irq at reset", 32'(irqPulse), 32'd0);
    swRead(12'h000, rd); chk("R1 control reset", rd, 32'd0);
    swRead(12'h004, rd); chk("R1 count reset", rd, 32'd64);
    swRead(12'h010, rd); chk("R1 unmapped offset", rd, 32'd0);

    // R2 clamp sweep
    for (int v = 120; v < 140; v += 3) begin
      swWrite(12'h004, 32'(v));
      swRead(12'h004, rd);
      chk("R2 count clamp", rd, (v > 128) ? 32'd128 : 32'(v));
    end
    swWrite(12'h004, 32'hFFFF_0001);
    swRead(12'h004, rd); chk("R2 large count", rd, 32'd128);
    swWrite(12'h004, 32'd3);
    swRead(12'h004, rd); chk("R2 small count", rd, 32'd3);

    // R1 address word read-back
    swWrite(12'h42C, 32'hCAFE_0123);
    swRead(12'h42C, rd); chk("R1 address word", rd, 32'hCAFE_0123);

    // transmit ring of three, wrap on the last
    for (int i = 0; i < 3; i++) begin
      txStat[i] = (32'(60 + 100 * i) << 16) | 32'h8000 | 32'h4000 | 32'h0800
                | ((i == 2) ? 32'h2000 : 32'h0) | ((i == 0) ? 32'h1000 : 32'h0);
      swWrite(12'h404 + 12'(8 * i), txAddrOf(i));
      swWrite(12'h400 + 12'(8 * i), txStat[i]);
    end
    repeat (5) @(negedge clk);
    chk("R11 no fetch while disabled", 32'(txReq), 32'd0);
    swWrite(12'h000, 32'd1);
    txFrame("r1", 0, 9'h000, txStat[0]);
    txFrame("r1", 1, 9'h030, txStat[1]);
    txFrame("r1", 2, 9'h004, txStat[2]);
    repeat (6) @(negedge clk);
    chk("R11 waits on unowned descriptor", 32'(txReq), 32'd0);

    // second round: pointer must be back at 0, one descriptor without irq
    txStat[1] = txStat[1] & ~32'h4000;
    for (int i = 0; i < 3; i++) swWrite(12'h400 + 12'(8 * i), txStat[i]);
    txFrame("R6 wrap", 0, 9'h108, txStat[0]);
    txFrame("r2", 1, 9'h010, txStat[1]);
    txFrame("r2", 2, 9'h002, txStat[2]);

    // R12 software write on the write-back cycle
    swWrite(12'h400, txStat[0]);
    waitTxReq();
    chk("R12 presented index", txBufAddr, txAddrOf(0));
    txDone = 1'b1; txResult = 9'h001;
    @(negedge clk);
    txDone = 1'b0;
    swWe = 1'b1; swAddr = 12'h400; swWdata = 32'h00C8_C000;
    @(negedge clk);
    swWe = 1'b0;
    chk("R12 irq deferred", 32'(irqPulse), 32'd0);
    #1 chk("R12 software value kept", swRdata, 32'h00C8_C000);
    @(negedge clk);
    chk("R12 irq after retry", 32'(irqPulse), 32'd2);
    #1 chk("R12 merged write-back", swRdata, 32'h00C8_4001);

    // R10 enable rise rewinds the transmit pointer (now at 1)
    swWrite(12'h000, 32'd0);
    swWrite(12'h400, txStat[0]);
    swWrite(12'h408, txStat[1]);
    swWrite(12'h000, 32'd1);
    txFrame("R10 rewind", 0, 9'h000, txStat[0]);
    txFrame("R10 follow", 1, 9'h000, txStat[1]);
    swWrite(12'h000, 32'd0);

    // receive ring at indices 3 and 4, wrap on 4, index 5 also empty
    for (int i = 3; i < 6; i++) begin
      rxStat[i] = 32'h8000 | 32'h4000 | ((i == 4) ? 32'h2000 : 32'h0);
      swWrite(12'h404 + 12'(8 * i), rxAddrOf(i));
      swWrite(12'h400 + 12'(8 * i), rxStat[i]);
    end
    rxRefused("disabled", 5'b00000);
    swWrite(12'h000, 32'd2);
    rxFrame("R10 start at N", 3, 16'd64, 9'h000, rxStat[3]);
    rxFrame("next", 4, 16'd100, 9'h002, rxStat[4]);
    rxRefused("full", 5'b10000);
    swWrite(12'h418, rxStat[3]);
    rxFrame("R6 wrap to N", 3, 16'd1518, 9'h010, rxStat[3]);
    rxRefused("full again", 5'b10000);
    swWrite(12'h000, 32'd0);
    rxRefused("disabled again", 5'b00000);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule